// File: doc/BRIEF.md
# I2C Power-Monitor Slave Transaction Engine

This block is the byte-level serial front end of a power-monitor device. It oversamples SCL and SDA with the system clock and recognises start and stop conditions. It matches a fixed 7-bit slave address and runs each transaction as a sequence of received or transmitted bytes. Its only bus output is an open-drain enable: when `sda_oe_o` is high, the pad pulls SDA low.

A write transaction is routed by the most significant bit of its first data byte. When that bit is clear, the byte is a command: its low seven bits go to the register bank as a one-cycle strobe. When that bit is set, the byte selects an extended register, and the following byte is delivered to that register.

A read transaction returns either one status byte or a packed data frame built from two 12-bit conversion results. While a one-shot conversion is still pending, the block refuses any read by leaving the address unacknowledged.

Top module: `i2c_mon_slave`

## Requirements
- R1: An address byte is acknowledged only when its upper seven bits equal `SLAVE_ADDR`. After any other address the block drives nothing and performs no write until the next start.
- R2: An address with the write bit (bit 0 = 0) followed directly by a stop is acknowledged and produces neither `cmd_we_o` nor `ext_we_o`.
- R3: In a write, a first data byte with bit 7 = 0 produces exactly one single-cycle `cmd_we_o` pulse, with `cmd_o` equal to the byte's bits 6..0.
- R4: A first data byte with bit 7 = 1, bits 6..2 = 0 and bits 1..0 in 1..3 is an extended register address. The next byte produces one `ext_we_o` pulse, with `ext_sel_o` equal to bits 1..0 and `ext_data_o` equal to that byte.
- R5: An extended address with bits 1..0 = 0, or with any of bits 6..2 set, is acknowledged, but the byte that follows it is acknowledged and dropped without `ext_we_o`.
- R6: Every byte the master writes is acknowledged. Bytes after a command byte, and bytes after an extended data byte, are acknowledged and dropped.
- R7: When `stat_sel_i` = 0 and both channel enables are set, a read returns three bytes in this order: volt[11:4], curr[11:4], {volt[3:0], curr[3:0]}.
- R8: When only `volt_en_i` is set, a read returns volt[11:4] and then {volt[3:0], 4'h0}. In any other non-status case it returns curr[11:4] and then {curr[3:0], 4'h0}.
- R9: When `stat_sel_i` = 1, a read returns the single byte `stat_i`. This takes precedence over the channel enables.
- R10: Bytes requested past the end of the frame read as 8'hFF. After the master answers a byte with NACK, the block releases SDA for the rest of the transaction.
- R11: While `conv_busy_i` is high, a read address is left unacknowledged, and write addresses are still acknowledged.
- R12: A repeated start re-enters address reception and clears the byte count. The first data byte after it is decoded as a new first byte.
- R13: The block changes `sda_oe_o` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data from the pad (resolved bus level) |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| cmd_we_o | output | 1 | One-cycle command write strobe |
| cmd_o | output | 7 | Command value |
| ext_we_o | output | 1 | One-cycle extended register write strobe |
| ext_sel_o | output | 2 | Extended register select (1..3) |
| ext_data_o | output | 8 | Extended register data |
| conv_busy_i | input | 1 | One-shot conversion pending: refuse reads |
| volt_en_i | input | 1 | Voltage channel enabled |
| curr_en_i | input | 1 | Current channel enabled |
| stat_sel_i | input | 1 | Reads return the status byte |
| volt_i | input | 12 | Latest voltage result |
| curr_i | input | 12 | Latest current result |
| stat_i | input | 8 | Status byte |

## Verification
The bench builds the block with its default parameters: address 7'h4A and a two-stage synchronizer. It bit-bangs the bus with eight system clocks per quarter SCL period, which keeps a full sweep of all 128 address values inside the run time. The small address space lets the bench probe every possible address. The 7-bit command space is swept with a coarse stride, every extended select value is combined with several data patterns, and each read mode is exercised over several result patterns, always reading one byte past the frame. The expected bytes are computed arithmetically from the channel values.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int unsigned ADC_W = 12;
  localparam int unsigned LO_W  = ADC_W - 8;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned IDX_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p[0] <= scl_i;
      sda_p[0] <= sda_i;
      for (int k = 1; k < int'(STAGES); k++) begin
        scl_p[k] <= scl_p[k-1];
        sda_p[k] <= sda_p[k-1];
      end
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_o      = scl_p[STAGES-1];
  assign sda_o      = sda_p[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // start/stop: SDA edge while SCL stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_mon_rdfmt.sv
module i2c_mon_rdfmt
  import i2c_mon_pkg::*;
(
  input  logic [ADC_W-1:0] volt_i,
  input  logic [ADC_W-1:0] curr_i,
  input  logic             volt_en_i,
  input  logic             curr_en_i,
  input  logic             stat_sel_i,
  input  logic [7:0]       stat_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  logic [7:0]       frame [3];
  logic [IDX_W-1:0] len;

  always_comb begin
    frame[0] = 8'hFF;
    frame[1] = 8'hFF;
    frame[2] = 8'hFF;
    if (stat_sel_i) begin
      len      = 2'd1;
      frame[0] = stat_i;
    end else if (volt_en_i && curr_en_i) begin
      len      = 2'd3;
      frame[0] = volt_i[ADC_W-1 -: 8];
      frame[1] = curr_i[ADC_W-1 -: 8];
      frame[2] = {volt_i[LO_W-1:0], curr_i[LO_W-1:0]};
    end else if (volt_en_i) begin
      len      = 2'd2;
      frame[0] = volt_i[ADC_W-1 -: 8];
      frame[1] = {volt_i[LO_W-1:0], {(8-LO_W){1'b0}}};
    end else begin
      len      = 2'd2;
      frame[0] = curr_i[ADC_W-1 -: 8];
      frame[1] = {curr_i[LO_W-1:0], {(8-LO_W){1'b0}}};
    end
    byte_o = (idx_i < len) ? frame[idx_i] : 8'hFF;
  end

  always_comb begin
    if (stat_sel_i && idx_i == 2'd0) begin
      AST_STAT_FIRST: assert (byte_o == stat_i); // R9
    end
  end
endmodule

// File: rtl/i2c_mon_slave.sv
module i2c_mon_slave
  import i2c_mon_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR  = 7'h4A,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             cmd_we_o,
  output logic [6:0]       cmd_o,
  output logic             ext_we_o,
  output logic [1:0]       ext_sel_o,
  output logic [7:0]       ext_data_o,
  input  logic             conv_busy_i,
  input  logic             volt_en_i,
  input  logic             curr_en_i,
  input  logic             stat_sel_i,
  input  logic [ADC_W-1:0] volt_i,
  input  logic [ADC_W-1:0] curr_i,
  input  logic [7:0]       stat_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_mon_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       byte_q;
  logic [7:0]       shift_q, tx_q;
  logic [IDX_W-1:0] rd_idx_q;
  logic             rw_q, ext_mode_q, ext_ok_q, mack_q, oe_q;
  logic             cmd_we_q, ext_we_q;
  logic [6:0]       cmd_q;
  logic [1:0]       ext_sel_q;
  logic [7:0]       ext_data_q;
  logic [7:0]       fmt_byte;

  i2c_mon_rdfmt i_rdfmt (
    .volt_i    (volt_i),
    .curr_i    (curr_i),
    .volt_en_i (volt_en_i),
    .curr_en_i (curr_en_i),
    .stat_sel_i(stat_sel_i),
    .stat_i    (stat_i),
    .idx_i     (rd_idx_q),
    .byte_o    (fmt_byte)
  );

  logic addr_hit;
  assign addr_hit = (shift_q[7:1] == SLAVE_ADDR) && (!shift_q[0] || !conv_busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      byte_q     <= '0;
      shift_q    <= '0;
      tx_q       <= '1;
      rd_idx_q   <= '0;
      rw_q       <= 1'b0;
      ext_mode_q <= 1'b0;
      ext_ok_q   <= 1'b0;
      mack_q     <= 1'b0;
      oe_q       <= 1'b0;
      cmd_we_q   <= 1'b0;
      ext_we_q   <= 1'b0;
      cmd_q      <= '0;
      ext_sel_q  <= '0;
      ext_data_q <= '0;
    end else begin
      cmd_we_q <= 1'b0;
      ext_we_q <= 1'b0;
      if (bus_stop) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (bus_start) begin
        // also covers repeated start
        st_q   <= ST_ADDR;
        cnt_q  <= '0;
        byte_q <= '0;
        oe_q   <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise) begin
              shift_q <= {shift_q[6:0], sda_s};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_W'(8)) begin
              if (addr_hit) begin
                oe_q     <= 1'b1;
                rw_q     <= shift_q[0];
                rd_idx_q <= '0;
                st_q     <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q     <= fmt_byte;
                oe_q     <= ~fmt_byte[7];
                rd_idx_q <= (rd_idx_q == '1) ? rd_idx_q : rd_idx_q + 1'b1;
                st_q     <= ST_RD_BYTE;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_BYTE: begin
            if (scl_rise) begin
              shift_q <= {shift_q[6:0], sda_s};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_W'(8)) begin
              oe_q <= 1'b1;
              st_q <= ST_WR_ACK;
              if (byte_q == 2'd0) begin
                if (!shift_q[7]) begin
                  cmd_we_q   <= 1'b1;
                  cmd_q      <= shift_q[6:0];
                  ext_mode_q <= 1'b0;
                end else begin
                  ext_mode_q <= 1'b1;
                  ext_sel_q  <= shift_q[1:0];
                  ext_ok_q   <= (shift_q[6:2] == 5'd0) && (shift_q[1:0] != 2'd0);
                end
              end else if (byte_q == 2'd1 && ext_mode_q && ext_ok_q) begin
                ext_we_q   <= 1'b1;
                ext_data_q <= shift_q;
              end
              if (byte_q != 2'd2) byte_q <= byte_q + 2'd1;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_fall) begin
              if (cnt_q == CNT_W'(7)) begin
                oe_q  <= 1'b0;
                cnt_q <= '0;
                st_q  <= ST_RD_ACK;
              end else begin
                cnt_q <= cnt_q + 1'b1;
                tx_q  <= {tx_q[6:0], 1'b1};
                oe_q  <= ~tx_q[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q     <= fmt_byte;
                oe_q     <= ~fmt_byte[7];
                rd_idx_q <= (rd_idx_q == '1) ? rd_idx_q : rd_idx_q + 1'b1;
                st_q     <= ST_RD_BYTE;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign cmd_we_o   = cmd_we_q;
  assign cmd_o      = cmd_q;
  assign ext_we_o   = ext_we_q;
  assign ext_sel_o  = ext_sel_q;
  assign ext_data_o = ext_data_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_s); // R13
  AST_CMD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |=> !cmd_we_o); // R3
  AST_EXT_SEL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_o |-> (ext_sel_o != 2'd0)); // R5
  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(oe_q) && st_q == ST_ADDR_ACK && rw_q) |-> !$past(conv_busy_i)); // R11
  AST_SKIP_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP) |-> !oe_q); // R10
endmodule

// File: tb/test_i2c_mon_slave.sv
module test_i2c_mon_slave;
  localparam logic [6:0] ADDR = 7'h4A;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic cmd_we, ext_we;
  logic [6:0] cmd;
  logic [1:0] ext_sel;
  logic [7:0] ext_data;
  logic busy = 1'b0, v_en = 1'b0, c_en = 1'b0, s_sel = 1'b0;
  logic [11:0] volt = '0, curr = '0;
  logic [7:0] stat = '0;

  int vectors = 0, miscompares = 0;
  int cmd_cnt = 0, ext_cnt = 0, viol = 0;
  logic [6:0] last_cmd = '0;
  logic [1:0] last_sel = '0;
  logic [7:0] last_data = '0;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_mon_slave #(.SLAVE_ADDR(ADDR)) i_i2c_mon_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .cmd_we_o(cmd_we), .cmd_o(cmd),
    .ext_we_o(ext_we), .ext_sel_o(ext_sel), .ext_data_o(ext_data),
    .conv_busy_i(busy), .volt_en_i(v_en), .curr_en_i(c_en), .stat_sel_i(s_sel),
    .volt_i(volt), .curr_i(curr), .stat_i(stat)
  );

  always @(negedge clk) begin
    if (cmd_we) begin cmd_cnt++; last_cmd = cmd; end
    if (ext_we) begin ext_cnt++; last_sel = ext_sel; last_data = ext_data; end
    if (rst_n && sda_oe != prev_oe && scl_m) viol++;
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic s);
    scl_m = 1'b0; tick(Q);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    s = sda_bus;  tick(Q);
  endtask

  task automatic i2c_start();
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  // mode: 0 both, 1 volt only, 2 curr only, 3 none, 4 status
  function automatic logic [7:0] exp_byte(input int mode, input int idx,
      input logic [11:0] v, input logic [11:0] c, input logic [7:0] st);
    int len = (mode == 4) ? 1 : (mode == 0) ? 3 : 2;
    if (idx >= len) return 8'hFF;
    case (mode)
      4: return st;
      0: return (idx == 0) ? 8'(v / 16) : (idx == 1) ? 8'(c / 16) : 8'((v % 16) * 16 + (c % 16));
      1: return (idx == 0) ? 8'(v / 16) : 8'((v % 16) * 16);
      default: return (idx == 0) ? 8'(c / 16) : 8'((c % 16) * 16);
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL R13 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int c0, e0;
    tick(5);
    chk("R1 reset oe", int'(sda_oe), 0);
    chk("R3 reset cmd_we", int'(cmd_we), 0);
    rst_n = 1'b1;
    tick(5);

    // R1: every address, write direction
    for (int a = 0; a < 128; a++) begin
      i2c_start();
      send_byte({7'(a), 1'b0}, ack);
      i2c_stop();
      chk("R1 addr ack", int'(ack), (a == int'(ADDR)) ? 1 : 0);
    end
    chk("R2 probe no cmd write", cmd_cnt, 0);
    chk("R2 probe no ext write", ext_cnt, 0);

    // R1: foreign address then data bytes are ignored
    i2c_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, ack);
    send_byte(8'h15, ack);
    chk("R1 foreign data nack", int'(ack), 0);
    i2c_stop();
    chk("R1 foreign no write", cmd_cnt, 0);

    // R3: command sweep
    for (int c = 0; c < 128; c += 5) begin
      c0 = cmd_cnt;
      i2c_start();
      send_byte({ADDR, 1'b0}, ack);
      send_byte({1'b0, 7'(c)}, ack);
      chk("R6 cmd byte ack", int'(ack), 1);
      i2c_stop();
      chk("R3 cmd count", cmd_cnt, c0 + 1);
      chk("R3 cmd value", int'(last_cmd), c);
    end

    // R4: extended writes
    for (int s = 1; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        logic [7:0] dv = 8'(d * 8'h55 + s);
        e0 = ext_cnt;
        i2c_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte({1'b1, 5'd0, 2'(s)}, ack);
        send_byte(dv, ack);
        chk("R6 ext data ack", int'(ack), 1);
        i2c_stop();
        chk("R4 ext count", ext_cnt, e0 + 1);
        chk("R4 ext sel", int'(last_sel), s);
        chk("R4 ext data", int'(last_data), int'(dv));
      end
    end

    // R5: invalid extended addresses
    foreach (rb[k]) begin
      logic [7:0] bad = (k < 4) ? 8'(8'h80 | (8'h04 << k)) : 8'(8'h80 | (8'h04 << (k - 4)) | 8'h02);
      if (k == 7) bad = 8'h80;
      e0 = ext_cnt;
      i2c_start();
      send_byte({ADDR, 1'b0}, ack);
      send_byte(bad, ack);
      chk("R5 bad ext addr ack", int'(ack), 1);
      send_byte(8'h3C, ack);
      chk("R5 bad ext data ack", int'(ack), 1);
      i2c_stop();
      chk("R5 bad ext dropped", ext_cnt, e0);
    end

    // R6: trailing bytes dropped
    c0 = cmd_cnt;
    e0 = ext_cnt;
    i2c_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h2B, ack);
    send_byte(8'h11, ack);
    send_byte(8'h92, ack);
    chk("R6 trailing ack", int'(ack), 1);
    i2c_stop();
    chk("R6 one cmd only", cmd_cnt, c0 + 1);
    chk("R6 cmd kept", int'(last_cmd), 8'h2B);
    chk("R6 no ext from trailing", ext_cnt, e0);
    i2c_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h82, ack);
    send_byte(8'h6E, ack);
    send_byte(8'hD4, ack);
    chk("R6 trailing ext ack", int'(ack), 1);
    i2c_stop();
    chk("R6 one ext only", ext_cnt, e0 + 1);
    chk("R6 ext data kept", int'(last_data), 8'h6E);

    // R7 R8 R9 R10: read modes
    for (int p = 0; p < 4; p++) begin
      volt = 12'(p * 12'h5A7 + 12'h0F1);
      curr = 12'(p * 12'h3C9 + 12'h80E);
      stat = 8'(p * 8'h4B + 8'h21);
      for (int m = 0; m < 5; m++) begin
        int len = (m == 4) ? 1 : (m == 0) ? 3 : 2;
        s_sel = (m == 4);
        v_en  = (m == 0) || (m == 1) || (m == 4);
        c_en  = (m == 0) || (m == 2) || (m == 4);
        i2c_start();
        send_byte({ADDR, 1'b1}, ack);
        chk("R11 read addr ack idle", int'(ack), 1);
        for (int i = 0; i <= len; i++) begin
          recv_byte(i != len, rb);
          if (i == len)   chk("R10 pad byte", int'(rb), 8'hFF);
          else if (m == 4) chk("R9 status byte", int'(rb), int'(exp_byte(m, i, volt, curr, stat)));
          else if (m == 0) chk("R7 both byte", int'(rb), int'(exp_byte(m, i, volt, curr, stat)));
          else             chk("R8 single byte", int'(rb), int'(exp_byte(m, i, volt, curr, stat)));
        end
        chk("R10 released after nack", int'(sda_oe), 0);
        i2c_stop();
      end
    end

    // R11: busy refuses reads only
    busy = 1'b1;
    i2c_start();
    send_byte({ADDR, 1'b1}, ack);
    i2c_stop();
    chk("R11 busy read nack", int'(ack), 0);
    c0 = cmd_cnt;
    i2c_start();
    send_byte({ADDR, 1'b0}, ack);
    chk("R11 busy write ack", int'(ack), 1);
    send_byte(8'h05, ack);
    i2c_stop();
    chk("R11 busy cmd", cmd_cnt, c0 + 1);
    busy = 1'b0;
    i2c_start();
    send_byte({ADDR, 1'b1}, ack);
    recv_byte(1'b0, rb);
    i2c_stop();
    chk("R11 idle read ack", int'(ack), 1);

    // R12: repeated start restarts byte count
    c0 = cmd_cnt;
    e0 = ext_cnt;
    i2c_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h81, ack);
    i2c_start();
    send_byte({ADDR, 1'b0}, ack);
    chk("R12 readdress ack", int'(ack), 1);
    send_byte(8'h22, ack);
    i2c_stop();
    chk("R12 no ext", ext_cnt, e0);
    chk("R12 cmd count", cmd_cnt, c0 + 1);
    chk("R12 cmd value", int'(last_cmd), 8'h22);
    s_sel = 1'b1;
    stat = 8'hC3;
    i2c_start();
    send_byte({ADDR, 1'b0}, ack);
    i2c_start();
    send_byte({ADDR, 1'b1}, ack);
    recv_byte(1'b0, rb);
    i2c_stop();
    chk("R12 read after restart", int'(rb), 8'hC3);

    chk("R13 oe changes while scl high", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule